// File: doc/BRIEF.md
# Vector Operand Swizzle Unit

This block conditions one source operand before it enters a four-lane vector arithmetic unit. The 128-bit source vector is split into four 32-bit lanes named x, y, z and w. For each destination lane a 3-bit code selects either any one of the four source lanes or a built-in constant. The constant set depends on the operation type. Integer operations get zero, one, minus one and two. Floating-point operations get 0.0, 1.0, -1.0 and a quiet NaN.

A single vector add, subtract, multiply, divide, min or max can therefore permute, broadcast or partly blank its inputs without a separate shuffle or constant-load step. For example, a 3D cross product needs only two multiplies, each with yzx and zxy swizzled operands, followed by one subtract. The unit is combinational by default. A parameter adds one output register stage with an asynchronous reset.

Top module: `vec_swizzle`

## Requirements
- R1: Lane x occupies bits [31:0], y [63:32], z [95:64] and w [127:96] of both `src_vec` and `operand`. The code for destination lane i sits at `lane_sel[3i+2:3i]`, and codes 0, 1, 2 and 3 copy source lane x, y, z or w unchanged into that destination lane.
- R2: The identity field `lane_sel` = 12'h688 (lane codes 0, 1, 2, 3 from x to w) passes the source vector through unchanged in both modes.
- R3: Code 4 gives 32'h00000000 in both modes.
- R4: Code 5 gives 32'h3F800000 (1.0) when `mode_fp` is 1 and 32'h00000001 when `mode_fp` is 0.
- R5: Code 6 gives 32'hBF800000 (-1.0) when `mode_fp` is 1 and 32'hFFFFFFFF when `mode_fp` is 0.
- R6: Code 7 gives the quiet NaN 32'h7FC00000 when `mode_fp` is 1 and 32'h00000002 when `mode_fp` is 0.
- R7: `mode_fp` affects only lanes whose code is 4 to 7. Lanes with source codes give the same result in both modes.
- R8: Each destination lane is selected independently. A source lane may feed several destination lanes (broadcast), and the permutations yzx and zxy on the first three lanes are produced exactly.
- R9: With `REG_OUT` = 0 the result appears in the same cycle as its inputs. With `REG_OUT` = 1 it appears after exactly one rising clock edge, and `operand` is all zeros while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the optional output register |
| mode_fp | input | 1 | 1 selects the floating-point constant set, 0 the integer set |
| lane_sel | input | 12 | Four 3-bit lane codes, lane x in the low bits |
| src_vec | input | 128 | Source vector of four 32-bit lanes |
| operand | output | 128 | Swizzled operand |

## Verification
Source-lane routing and constant injection can occur in the same cycle, in different destination lanes of one result. The mode bit then decides the constant lanes while the routed lanes must ignore it. Every one of the 4096 selector fields is applied in each mode, with distinct lane values that change at every step, so each mix of routed and constant lanes is produced. Each result is compared against an arithmetic reference, on the combinational instance in the same cycle and on the registered instance one edge later.

// File: rtl/swz_pkg.sv
package swz_pkg;

   typedef enum logic [2:0] {
      SWZ_X    = 3'd0,
      SWZ_Y    = 3'd1,
      SWZ_Z    = 3'd2,
      SWZ_W    = 3'd3,
      SWZ_ZERO = 3'd4,
      SWZ_ONE  = 3'd5,
      SWZ_NEG1 = 3'd6,
      SWZ_TOP  = 3'd7
   } swz_code_e;

   localparam int CONST_COUNT = 4;

   localparam logic [31:0] FP32_ZERO = 32'h0000_0000;
   localparam logic [31:0] FP32_ONE  = 32'h3F80_0000;
   localparam logic [31:0] FP32_NEG1 = 32'hBF80_0000;
   localparam logic [31:0] FP32_QNAN = 32'h7FC0_0000;

endpackage

// File: rtl/swz_const_set.sv
module swz_const_set #(
   parameter int LANE_W = 32,
   localparam int SET_W = swz_pkg::CONST_COUNT * LANE_W
) (
   input  logic             mode_fp,
   output logic [SET_W-1:0] consts
);

   logic [SET_W-1:0] int_set;
   logic [SET_W-1:0] fp_set;

   // integer set: index 0 zero, 1 one, 2 all ones, 3 two
   assign int_set = {LANE_W'(2), {LANE_W{1'b1}}, LANE_W'(1), LANE_W'(0)};

   generate
      if (LANE_W == 32) begin : g_fp32
         assign fp_set = {swz_pkg::FP32_QNAN, swz_pkg::FP32_NEG1,
                          swz_pkg::FP32_ONE,  swz_pkg::FP32_ZERO};
      end else begin : g_fp_bad
         $error("swz_const_set: floating constants need 32-bit lanes");
         assign fp_set = '0;
      end
   endgenerate

   always_comb begin
      consts = mode_fp ? fp_set : int_set;
   end

endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux #(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   localparam int IDX_W = $clog2(LANES),
   localparam int SEL_W = IDX_W + 1,
   localparam int VEC_W = LANES * LANE_W,
   localparam int SET_W = swz_pkg::CONST_COUNT * LANE_W
) (
   input  logic [VEC_W-1:0]  src,
   input  logic [SEL_W-1:0]  code,
   input  logic [SET_W-1:0]  consts,
   output logic [LANE_W-1:0] lane_out
);

   logic              use_const;
   logic [IDX_W-1:0]  src_idx;
   logic [1:0]        const_idx;

   assign use_const = code[SEL_W-1];
   assign src_idx   = code[IDX_W-1:0];
   assign const_idx = code[1:0];

   always_comb begin
      if (use_const) begin
         lane_out = consts[int'(const_idx)*LANE_W +: LANE_W];
      end else begin
         lane_out = src[int'(src_idx)*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/vec_swizzle.sv
module vec_swizzle #(
   parameter int LANES   = 4,
   parameter int LANE_W  = 32,
   parameter bit REG_OUT = 1'b0,
   localparam int IDX_W  = $clog2(LANES),
   localparam int SEL_W  = IDX_W + 1,
   localparam int VEC_W  = LANES * LANE_W,
   localparam int SELF_W = LANES * SEL_W,
   localparam int SET_W  = swz_pkg::CONST_COUNT * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_fp,
   input  logic [SELF_W-1:0] lane_sel,
   input  logic [VEC_W-1:0]  src_vec,
   output logic [VEC_W-1:0]  operand
);

   generate
      if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("vec_swizzle: LANES must be a power of two of at least 4");
      end
   endgenerate

   logic [SET_W-1:0] const_set;
   logic [VEC_W-1:0] swz_vec;

   swz_const_set #(
      .LANE_W (LANE_W)
   ) u_consts (
      .mode_fp (mode_fp),
      .consts  (const_set)
   );

   generate
      for (genvar li = 0; li < LANES; li++) begin : g_lane
         swz_lane_mux #(
            .LANES  (LANES),
            .LANE_W (LANE_W)
         ) u_mux (
            .src      (src_vec),
            .code     (lane_sel[li*SEL_W +: SEL_W]),
            .consts   (const_set),
            .lane_out (swz_vec[li*LANE_W +: LANE_W])
         );
      end

      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               operand <= '0;
            end else begin
               operand <= swz_vec;
            end
         end
      end else begin : g_comb_out
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign operand = swz_vec;
      end
   endgenerate

endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
   parameter int LANES   = 4,
   parameter int LANE_W  = 32,
   parameter bit REG_OUT = 1'b0,
   localparam int IDX_W  = $clog2(LANES),
   localparam int SEL_W  = IDX_W + 1,
   localparam int VEC_W  = LANES * LANE_W,
   localparam int SELF_W = LANES * SEL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_fp,
   input logic [SELF_W-1:0] lane_sel,
   input logic [VEC_W-1:0]  src_vec,
   input logic [VEC_W-1:0]  operand
);

   logic              h_mode;
   logic [SELF_W-1:0] h_sel;
   logic [VEC_W-1:0]  h_src;
   logic              h_ok;
   logic [SELF_W-1:0] ident;

   generate
      if (REG_OUT) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               h_mode <= 1'b0;
               h_sel  <= '0;
               h_src  <= '0;
               h_ok   <= 1'b0;
            end else begin
               h_mode <= mode_fp;
               h_sel  <= lane_sel;
               h_src  <= src_vec;
               h_ok   <= 1'b1;
            end
         end
      end else begin : g_direct
         assign h_mode = mode_fp;
         assign h_sel  = lane_sel;
         assign h_src  = src_vec;
         assign h_ok   = 1'b1;
      end

      for (genvar ii = 0; ii < LANES; ii++) begin : g_ident
         assign ident[ii*SEL_W +: SEL_W] = SEL_W'(ii);
      end
   endgenerate

   // R2: identity field reproduces the source
   p_identity_r2: assert property (@(posedge clk) disable iff (!rst_n || !h_ok)
      (h_sel == ident) |-> (operand == h_src));

   generate
      for (genvar ci = 0; ci < LANES; ci++) begin : g_lane_chk
         logic [SEL_W-1:0]  c;
         logic [LANE_W-1:0] o;
         assign c = h_sel[ci*SEL_W +: SEL_W];
         assign o = operand[ci*LANE_W +: LANE_W];

         p_route_r1: assert property (@(posedge clk) disable iff (!rst_n || !h_ok)
            !c[SEL_W-1] |-> (o == h_src[int'(c[IDX_W-1:0])*LANE_W +: LANE_W]));

         p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n || !h_ok)
            (c == SEL_W'(4)) |-> (o == '0));

         if (LANE_W == 32 && SEL_W == 3) begin : g_w32
            p_one_r4: assert property (@(posedge clk) disable iff (!rst_n || !h_ok)
               (c == 3'd5) |-> (o == (h_mode ? 32'h3F80_0000 : 32'h0000_0001)));

            p_minus_r5: assert property (@(posedge clk) disable iff (!rst_n || !h_ok)
               (c == 3'd6) |-> (o == (h_mode ? 32'hBF80_0000 : 32'hFFFF_FFFF)));

            p_top_r6: assert property (@(posedge clk) disable iff (!rst_n || !h_ok)
               (c == 3'd7) |-> (o == (h_mode ? 32'h7FC0_0000 : 32'h0000_0002)));
         end
      end
   endgenerate

endmodule

bind vec_swizzle swz_checker #(
   .LANES   (LANES),
   .LANE_W  (LANE_W),
   .REG_OUT (REG_OUT)
) u_swz_chk (.*);

// File: tb/test_vec_swizzle.sv
`timescale 1ns/1ps
module test_vec_swizzle;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_fp = 1'b0;
   logic [11:0]  lane_sel = '0;
   logic [127:0] src_vec = '0;
   logic [127:0] operand;
   logic [127:0] operand_q;

   int n_checks = 0;
   int n_fail   = 0;

   logic [127:0] prev_exp;
   bit           prev_valid = 1'b0;
   string        prev_tag;

   always #4 clk = ~clk;

   vec_swizzle i_vec_swizzle (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_fp  (mode_fp),
      .lane_sel (lane_sel),
      .src_vec  (src_vec),
      .operand  (operand)
   );

   vec_swizzle #(.REG_OUT(1'b1)) i_vec_swizzle_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_fp  (mode_fp),
      .lane_sel (lane_sel),
      .src_vec  (src_vec),
      .operand  (operand_q)
   );

   function automatic logic [31:0] ref_lane(bit fp, logic [2:0] c, logic [127:0] v);
      case (c)
         3'd4:    return 32'h0000_0000;
         3'd5:    return fp ? 32'h3F80_0000 : 32'h0000_0001;
         3'd6:    return fp ? 32'hBF80_0000 : 32'hFFFF_FFFF;
         3'd7:    return fp ? 32'h7FC0_0000 : 32'h0000_0002;
         default: return v[32*int'(c) +: 32];
      endcase
   endfunction

   function automatic logic [127:0] ref_vec(bit fp, logic [11:0] s, logic [127:0] v);
      logic [127:0] r;
      for (int i = 0; i < 4; i++) r[32*i +: 32] = ref_lane(fp, s[3*i +: 3], v);
      return r;
   endfunction

   function automatic string code_tag(logic [2:0] c);
      case (c)
         3'd4:    return "R3";
         3'd5:    return "R4";
         3'd6:    return "R5";
         3'd7:    return "R6";
         default: return "R1";
      endcase
   endfunction

   function automatic string auto_tag(logic [11:0] s, logic [127:0] act, logic [127:0] exp);
      for (int i = 0; i < 4; i++)
         if (act[32*i +: 32] !== exp[32*i +: 32]) return code_tag(s[3*i +: 3]);
      return "R1";
   endfunction

   function automatic logic [127:0] mk_src(int n);
      logic [127:0] v;
      logic [31:0]  mix;
      mix = 32'(n) * 32'h9E37_79B9;
      for (int i = 0; i < 4; i++) v[32*i +: 32] = (32'h1111_1111 * 32'(i + 1)) ^ mix;
      return v;
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic flush_reg();
      if (prev_valid) check(prev_tag, operand_q, prev_exp);
      prev_valid = 1'b0;
   endtask

   // drive on the falling edge, judge the combinational copy 1 ns later,
   // judge the registered copy at the following falling edge
   task automatic apply(bit fp, logic [11:0] s, logic [127:0] v, string tag);
      logic [127:0] e;
      string        t;
      @(negedge clk);
      flush_reg();
      mode_fp  = fp;
      lane_sel = s;
      src_vec  = v;
      e = ref_vec(fp, s, v);
      #1;
      t = (tag == "") ? auto_tag(s, operand, e) : tag;
      check(t, operand, e);
      prev_exp   = e;
      prev_valid = 1'b1;
      prev_tag   = (tag == "") ? "R9" : tag;
   endtask

   initial begin
      #(200000 * 8);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int step;
      step = 0;
      src_vec = mk_src(99);
      lane_sel = 12'h688;
      @(negedge clk);
      @(negedge clk);
      // R9: registered output cleared during reset
      check("R9", operand_q, 128'h0);
      rst_n = 1'b1;

      // R2: identity in both modes
      apply(1'b0, 12'h688, mk_src(1), "R2");
      apply(1'b1, 12'h688, mk_src(1), "R2");
      // R7: source lanes unaffected by the mode bit
      apply(1'b1, 12'h688, mk_src(2), "R7");
      check("R7", operand, mk_src(2));
      apply(1'b0, 12'h688, mk_src(2), "R7");
      check("R7", operand, mk_src(2));
      // R8: yzx and zxy permutations with w forced to zero, and a z broadcast
      apply(1'b1, {3'd4, 3'd0, 3'd2, 3'd1}, mk_src(3), "R8");
      apply(1'b1, {3'd4, 3'd1, 3'd0, 3'd2}, mk_src(4), "R8");
      apply(1'b0, {3'd2, 3'd2, 3'd2, 3'd2}, mk_src(5), "R8");

      // exhaustive selector sweep in both modes (R1, R3 to R6, R9)
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4096; s++) begin
            apply(m[0], 12'(s), mk_src(step), "");
            step++;
         end
      end
      @(negedge clk);
      flush_reg();

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule